// File: doc/BRIEF.md
# Two-Wire Serial Slave with Eight-Entry Control Register Bank

This block lets a host processor read and write eight 8-bit control registers over a two-wire serial bus. It runs on a fast system clock and treats the bus clock and data lines as plain inputs. Each line passes through a two-flop synchroniser, and edge detection follows. A falling data edge while the bus clock is high opens a transaction. A rising data edge while the bus clock is high closes it. Only a frame whose 7-bit device address matches the fixed parameter gets an answer. The all-zero broadcast address is never answered.

A write frame carries a register pointer in its first data byte. Each data byte after that lands in the register the pointer selects, and the pointer then steps forward modulo eight. A burst longer than eight bytes therefore wraps round and overwrites the oldest entries first. A read frame streams register contents out MSB first, starting at the current pointer and wrapping in the same way. It continues until the host withholds its acknowledge. The data line is driven only through an active-high pull-low enable. An external pad or the bench forms the wired-AND bus.

The register contents are also presented in parallel, so the logic around the block can use them as configuration.

Top module: `i2c_cfg_slave`

## Requirements
- R1: After reset the pull-low enable is 0 and all eight registers read 0x00.
- R2: When the address byte's upper seven bits equal DEV_ADDR, the slave holds the data line low for the whole high phase of the ninth clock pulse. Bit 0 of the address byte is the direction flag: 0 means write, 1 means read. On any other address it leaves the line released, and it ignores the bytes that follow until the next START or STOP.
- R3: The all-zero address byte gets no acknowledge, and the data bytes that follow change no register.
- R4: In a write frame, the first data byte sets the pointer from its bits [2:0]. Each later byte is written to the register the pointer selects, and the pointer then advances by one. Every byte received while addressed is acknowledged.
- R5: The pointer wraps from 7 to 0. A write burst of more than eight bytes overwrites the earliest registers in the order they were first written.
- R6: In a read frame, bytes leave MSB first, starting at the current pointer. The pointer advances modulo 8 after each byte.
- R7: If the host leaves the data line high in the acknowledge slot of a read byte, the slave stops driving. It keeps the line released for all further clock pulses until a START or STOP.
- R8: A STOP returns the slave to idle. Clock pulses with no START before them get no acknowledge and write nothing.
- R9: A repeated START, with no STOP before it, begins a new address phase. A read may follow a pointer write in the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| cfg_regs_o | output | 64 | Register contents, register k at bits [8k+7:8k] |

## Verification
The bench aims at the pointer wrap, both in a ten-byte write starting at register 6 and in a ten-byte read over the same range. A pointer that saturated or reset would leave registers 0 and 1 stale, or would return the wrong bytes on the wrapped read. It sends a foreign address and the all-zero address and then clocks data after each. A slave that matched loosely would acknowledge and corrupt registers. It checks that the line stays released after a host NACK and after a STOP. A design that kept transmitting, or that decoded bits with no START, would pull the line low. A repeated START is used to switch from pointer write to read, which catches a slave that only re-arms on STOP.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_TACK,
    ST_PARK
  } slv_state_t;
endpackage

// File: rtl/i2c_cfg_sync.sv
module i2c_cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs #(
  parameter int NREG = 8,
  parameter int DW   = 8,
  localparam int PW  = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [PW-1:0]    raddr,
  output logic [DW-1:0]    rdata,
  output logic [NREG*DW-1:0] flat_o
);
  logic [DW-1:0] mem_q [NREG];

  generate
    for (genvar k = 0; k < NREG; k++) begin : g_reg
      logic hit;
      assign hit = we && (waddr == PW'(k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q[k] <= '0;
        else if (hit) mem_q[k] <= wdata;
      end
      assign flat_o[k*DW +: DW] = mem_q[k];
    end
  endgenerate

  assign rdata = mem_q[raddr];

  // R4: a write strobe lands the byte in the addressed register
  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/i2c_cfg_ctrl.sv
module i2c_cfg_ctrl
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2D,
  parameter int NREG = 8,
  parameter int DW   = 8,
  localparam int PW  = $clog2(NREG),
  localparam int CW  = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_lvl,
  input  logic          scl_prev,
  input  logic          sda_lvl,
  input  logic          sda_prev,
  input  logic [DW-1:0] rdata,
  output logic          sda_oe,
  output logic          we,
  output logic [PW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic [PW-1:0] raddr
);
  localparam logic [CW-1:0] BITS_FULL = CW'(DW);
  localparam logic [CW-1:0] BITS_LAST = CW'(DW - 1);
  localparam logic [PW-1:0] PTR_LAST  = PW'(NREG - 1);

  slv_state_t    state_q, state_n;
  logic [CW-1:0] bitcnt_q, bitcnt_n;
  logic [DW-1:0] shreg_q, shreg_n;
  logic [PW-1:0] ptr_q, ptr_n;
  logic          rw_q, rw_n;
  logic          first_q, first_n;
  logic          mack_q, mack_n;
  logic          ptr_step;

  logic scl_rise, scl_fall, start_det, stop_det, addr_hit, addr_zero;
  assign scl_rise  =  scl_lvl && !scl_prev;
  assign scl_fall  = !scl_lvl &&  scl_prev;
  assign start_det =  scl_lvl &&  scl_prev && !sda_lvl &&  sda_prev;
  assign stop_det  =  scl_lvl &&  scl_prev &&  sda_lvl && !sda_prev;
  assign addr_zero = (shreg_q[7:1] == 7'd0);
  assign addr_hit  = (shreg_q[7:1] == DEV_ADDR) && !addr_zero;

  always_comb begin
    state_n  = state_q;
    bitcnt_n = bitcnt_q;
    shreg_n  = shreg_q;
    ptr_n    = ptr_q;
    rw_n     = rw_q;
    first_n  = first_q;
    mack_n   = mack_q;
    we       = 1'b0;
    ptr_step = 1'b0;
    if (stop_det) begin
      state_n = ST_IDLE;
    end else if (start_det) begin
      state_n  = ST_ADDR;
      bitcnt_n = '0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise && bitcnt_q != BITS_FULL) begin
            shreg_n  = {shreg_q[DW-2:0], sda_lvl};
            bitcnt_n = bitcnt_q + 1'b1;
          end else if (scl_fall && bitcnt_q == BITS_FULL) begin
            if (state_q == ST_ADDR) begin
              if (addr_hit) begin
                state_n = ST_AACK;
                rw_n    = shreg_q[0];
              end else begin
                state_n = ST_PARK;
              end
            end else begin
              state_n = ST_RACK;
              if (first_q) begin
                ptr_n   = shreg_q[PW-1:0];
                first_n = 1'b0;
              end else begin
                we       = 1'b1;
                ptr_step = 1'b1;
              end
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            bitcnt_n = '0;
            if (rw_q) begin
              state_n = ST_TX;
              shreg_n = rdata;
            end else begin
              state_n = ST_RX;
              first_n = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            state_n  = ST_RX;
            bitcnt_n = '0;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt_q == BITS_LAST) begin
              state_n  = ST_TACK;
              ptr_step = 1'b1;
            end else begin
              shreg_n  = {shreg_q[DW-2:0], 1'b0};
              bitcnt_n = bitcnt_q + 1'b1;
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) mack_n = !sda_lvl;
          if (scl_fall) begin
            if (mack_q) begin
              state_n  = ST_TX;
              shreg_n  = rdata;
              bitcnt_n = '0;
            end else begin
              state_n = ST_PARK;
            end
          end
        end
        default: ;
      endcase
      if (ptr_step) ptr_n = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      ptr_q    <= '0;
      rw_q     <= 1'b0;
      first_q  <= 1'b0;
      mack_q   <= 1'b0;
    end else begin
      state_q  <= state_n;
      bitcnt_q <= bitcnt_n;
      shreg_q  <= shreg_n;
      ptr_q    <= ptr_n;
      rw_q     <= rw_n;
      first_q  <= first_n;
      mack_q   <= mack_n;
    end
  end

  assign sda_oe = (state_q == ST_AACK) || (state_q == ST_RACK) ||
                  ((state_q == ST_TX) && !shreg_q[DW-1]);
  assign waddr  = ptr_q;
  assign wdata  = shreg_q;
  assign raddr  = ptr_q;

  // R2: a matching address is answered on the next cycle
  assert_ack_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && scl_fall && bitcnt_q == BITS_FULL && addr_hit) |=> sda_oe);
  // R2: the line enable never moves while the bus clock stays high
  assert_oe_steady_scl_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && scl_prev) |-> $stable(sda_oe));
  // R3: broadcast address is left unanswered
  assert_no_gc_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && scl_fall && bitcnt_q == BITS_FULL && addr_zero) |=> !sda_oe);
  // R5: pointer wraps from the last register to register 0
  assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_step && ptr_q == PTR_LAST && !stop_det && !start_det) |=> (ptr_q == '0));
  // R7: host NACK releases the line
  assert_nack_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TACK && scl_fall && !mack_q && !stop_det && !start_det) |=> !sda_oe);
  // R8: STOP leaves the line released and the slave idle
  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && state_q == ST_IDLE));
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h2D,
  parameter int NREG    = 8,
  parameter int DW      = 8,
  parameter int SYNC_FF = 2,
  localparam int PW     = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [NREG*DW-1:0] cfg_regs_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic scl_lvl, scl_prev, sda_lvl, sda_prev;
  logic          we;
  logic [PW-1:0] waddr, raddr;
  logic [DW-1:0] wdata, rdata;

  i2c_cfg_sync #(.STAGES(SYNC_FF)) u_scl_sync (
    .clk(clk), .rst_n(rst_int_n), .pin_i(scl_i), .lvl_o(scl_lvl), .prev_o(scl_prev));
  i2c_cfg_sync #(.STAGES(SYNC_FF)) u_sda_sync (
    .clk(clk), .rst_n(rst_int_n), .pin_i(sda_i), .lvl_o(sda_lvl), .prev_o(sda_prev));

  i2c_cfg_ctrl #(.DEV_ADDR(DEV_ADDR), .NREG(NREG), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .scl_lvl(scl_lvl), .scl_prev(scl_prev), .sda_lvl(sda_lvl), .sda_prev(sda_prev),
    .rdata(rdata), .sda_oe(sda_oe_o), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr));

  i2c_cfg_regs #(.NREG(NREG), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata), .flat_o(cfg_regs_o));

  // R1: the line is released while reset is held
  assert_reset_release_R1: assert property (@(posedge clk) !rst_int_n |-> !sda_oe_o);
endmodule

// File: tb/i2c_cfg_slave_bench.sv
`timescale 1ns/1ps
module i2c_cfg_slave_bench;
  localparam int HP = 8;
  localparam logic [7:0] AW = 8'h5A;
  localparam logic [7:0] AR = 8'h5B;
  localparam int NV = 6;
  localparam logic [10:0] VEC [NV] = '{
    {3'd0, 8'hA5}, {3'd7, 8'h3C}, {3'd3, 8'hFF},
    {3'd4, 8'h00}, {3'd1, 8'h5A}, {3'd2, 8'hC3}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [63:0] regs;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] exp_r [8];

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_cfg_slave u_i2c_cfg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .cfg_regs_o(regs));

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] packed_exp();
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = exp_r[k];
    return v;
  endfunction

  task automatic bus_start();
    wt(HP/2); sda_m = 1'b1; wt(HP/2); scl_m = 1'b1; wt(HP);
    sda_m = 1'b0; wt(HP); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wt(HP/2); sda_m = 1'b0; wt(HP/2); scl_m = 1'b1; wt(HP);
    sda_m = 1'b1; wt(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_e, output logic ack_l);
    for (int i = 7; i >= 0; i--) begin
      wt(HP/2); sda_m = b[i]; wt(HP/2); scl_m = 1'b1; wt(HP); scl_m = 1'b0;
    end
    wt(HP/2); sda_m = 1'b1; wt(HP/2); scl_m = 1'b1;
    wt(1); ack_e = ~sda_line;
    wt(HP-2); ack_l = ~sda_line;
    wt(1); scl_m = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic host_ack);
    for (int i = 7; i >= 0; i--) begin
      wt(HP/2); sda_m = 1'b1; wt(HP/2); scl_m = 1'b1;
      wt(HP/2); b[i] = sda_line; wt(HP/2); scl_m = 1'b0;
    end
    wt(HP/2); sda_m = host_ack ? 1'b0 : 1'b1; wt(HP/2); scl_m = 1'b1;
    wt(HP); scl_m = 1'b0;
  endtask

  task automatic write_ok(input logic [7:0] b, input string req);
    logic e, l;
    send_byte(b, e, l);
    chk(req, {e, l}, 2'b11);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic e, l, low_seen;
    logic [7:0] rb;
    logic [7:0] d;
    for (int k = 0; k < 8; k++) exp_r[k] = 8'h00;
    wt(5);
    rst_n = 1'b1;
    wt(6);
    // R1: reset state
    chk("R1 oe", sda_oe, 1'b0);
    chk("R1 regs", regs, 64'h0);

    // Table: single write then pointer-set and read back (R4, R6)
    for (int v = 0; v < NV; v++) begin
      bus_start();
      write_ok(AW, "R2 addr ack");
      write_ok({5'd0, VEC[v][10:8]}, "R4 ptr ack");
      write_ok(VEC[v][7:0], "R4 data ack");
      bus_stop();
      exp_r[VEC[v][10:8]] = VEC[v][7:0];
      chk("R4 regs", regs, packed_exp());
      bus_start();
      write_ok(AW, "R2 addr ack");
      write_ok({5'd0, VEC[v][10:8]}, "R4 ptr ack");
      bus_stop();
      bus_start();
      write_ok(AR, "R2 read addr ack");
      recv_byte(rb, 1'b0);
      bus_stop();
      chk("R6 read", rb, VEC[v][7:0]);
    end

    // R2: foreign address, then data: no ack, no write
    bus_start();
    send_byte(8'h40, e, l); chk("R2 foreign no ack", {e, l}, 2'b00);
    send_byte(8'h00, e, l); chk("R2 ignored byte", {e, l}, 2'b00);
    send_byte(8'h77, e, l); chk("R2 ignored byte", {e, l}, 2'b00);
    bus_stop();
    chk("R2 regs unchanged", regs, packed_exp());

    // R3: all-zero address
    bus_start();
    send_byte(8'h00, e, l); chk("R3 gc no ack", {e, l}, 2'b00);
    send_byte(8'h01, e, l); chk("R3 ignored byte", {e, l}, 2'b00);
    send_byte(8'h99, e, l); chk("R3 ignored byte", {e, l}, 2'b00);
    bus_stop();
    chk("R3 regs unchanged", regs, packed_exp());

    // R5: ten-byte write from register 6 wraps
    bus_start();
    write_ok(AW, "R2 addr ack");
    write_ok(8'h06, "R4 ptr ack");
    for (int i = 0; i < 10; i++) begin
      d = 8'h11 * 8'(i + 1) ^ 8'h80;
      write_ok(d, "R5 burst ack");
      exp_r[(6 + i) % 8] = d;
    end
    bus_stop();
    chk("R5 wrap regs", regs, packed_exp());

    // R6: ten-byte read from register 6 wraps, R7: NACK releases
    bus_start();
    write_ok(AW, "R2 addr ack");
    write_ok(8'h06, "R4 ptr ack");
    bus_stop();
    bus_start();
    write_ok(AR, "R2 read addr ack");
    for (int i = 0; i < 10; i++) begin
      recv_byte(rb, i != 9);
      chk("R6 burst read", rb, exp_r[(6 + i) % 8]);
    end
    low_seen = 1'b0;
    for (int i = 0; i < 9; i++) begin
      wt(HP/2); sda_m = 1'b1; wt(HP/2); scl_m = 1'b1;
      wt(HP/2); if (!sda_line) low_seen = 1'b1; wt(HP/2); scl_m = 1'b0;
    end
    chk("R7 released after nack", low_seen, 1'b0);
    bus_stop();

    // R8: pulses with no START after STOP
    wt(HP); scl_m = 1'b0;
    send_byte(AW, e, l); chk("R8 no start no ack", {e, l}, 2'b00);
    send_byte(8'h02, e, l); chk("R8 no start no ack", {e, l}, 2'b00);
    send_byte(8'hEE, e, l); chk("R8 no start no ack", {e, l}, 2'b00);
    wt(HP/2); sda_m = 1'b1; wt(HP/2); scl_m = 1'b1; wt(HP);
    chk("R8 regs unchanged", regs, packed_exp());

    // R9: repeated START from pointer write into read
    bus_start();
    write_ok(AW, "R9 addr ack");
    write_ok(8'h03, "R9 ptr ack");
    bus_start();
    write_ok(AR, "R9 read addr ack");
    recv_byte(rb, 1'b0);
    bus_stop();
    chk("R9 read after rs", rb, exp_r[3]);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule